// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the timing strobes for one serial channel. A reference clock is divided by a programmable divisor that has a 16-bit integer part and a 4-bit fractional part counted in sixteenths. The result is a sample strobe at the oversampling rate. A second counter turns every 16 or every 8 sample strobes into one bit strobe, which marks one serial bit period. An optional divide-by-4 stage in front of the divisor extends the range toward slow rates.

Software picks the divisor as the integer part of the wanted ratio plus the remainder, rounded to the nearest sixteenth. The fractional sixteenths are spread over successive sample periods. The average sample period then equals the programmed value, and no single period differs by more than one prescaled clock. The divisor, fraction, prescaler and mode inputs are plain register values. The block takes a new setting only at the end of a period, so software may change them at any time.

Top module: `frac_baud_gen`

## Requirements
- R1: After a synchronous active-low reset, `sample_tick` and `bit_tick` are low. The internal period state is cleared.
- R2: With `pre_div4`=0 and fraction 0, `sample_tick` pulses once every D reference clocks. D is `{div_hi,div_lo}`, so for D=5 it pulses 32 times in any 160-clock window.
- R3: With fraction F, a 4-bit accumulator adds F at each period load. A period is one prescaled clock longer when that addition carries out of 4 bits. In every 16 consecutive periods exactly F are stretched, so D=5 with F=4 gives 64 pulses in 336 clocks, and D=3 with F=15 gives 160 pulses in 630 clocks.
- R4: With `pre_div4`=1, the divisor counts only one clock in four. The divide-by-4 counter runs freely from reset, so D=2 gives one pulse every 8 clocks.
- R5: `bit_tick` pulses in the same cycle as every 16th `sample_tick` when `os_8x`=0, and as every 8th when `os_8x`=1. `bit_tick` is never high without `sample_tick`.
- R6: An integer divisor of zero stops the strobes. No `sample_tick` or `bit_tick` occurs while the active divisor is zero, and the fractional accumulator is cleared.
- R7: A change to the divisor or the fraction is taken only when a period ends. The period in progress keeps its length. With D changed from 20 to 3 mid-period, the next gap is 20 clocks and the following gap is 3.
- R8: A change of `os_8x` is taken only at a bit boundary, or while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_lo | input | 8 | Low byte of the integer divisor |
| div_hi | input | 8 | High byte of the integer divisor |
| div_frac | input | 4 | Fractional divisor in sixteenths |
| pre_div4 | input | 1 | 1 = divide the reference clock by 4 before the divisor |
| os_8x | input | 1 | 1 = 8 samples per bit, 0 = 16 samples per bit |
| sample_tick | output | 1 | One-cycle strobe per sample period |
| bit_tick | output | 1 | One-cycle strobe per bit period |

## Verification
The assertions check these properties on every clock:
- the period count stays below the loaded length while running;
- the length holds steady between period ends;
- no strobe follows an idle cycle;
- the prescaler never fires on two clocks in a row;
- the sample index stays inside the active oversampling range;
- `bit_tick` always coincides with `sample_tick`.

Only the bench scenarios can show the following:
- that stretched periods number exactly F per sixteen;
- the real pulse rates with and without the prescaler;
- that a mid-period divisor write leaves the running period intact;
- that a mode change waits for the bit boundary.

The bench shows these by comparing the outputs every clock with a behavioural model and by counting pulses over fixed windows.

// File: rtl/baud_pkg.sv
// Package: shared encodings for the fractional baud rate generator.
// Assumes: consumers import it; it holds no state.
package baud_pkg;
    // Oversampling mode as seen on the mode input.
    typedef enum logic {
        OS_16X = 1'b0,
        OS_8X  = 1'b1
    } os_mode_e;
endpackage

// File: rtl/baud_prescale.sv
// Module: baud_prescale
// Gives a count enable: every clock when bypassed, otherwise one clock
// in RATIO. The phase counter runs freely from reset.
// Assumes: RATIO >= 2.
module baud_prescale #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    output logic cnt_en
);
    localparam int PW = $clog2(RATIO);
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic [PW-1:0] phase;

    // Free-running phase counter that wraps at RATIO.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    // Enable is either every clock or the last phase only.
    always_comb cnt_en = div_sel ? (phase == LAST) : 1'b1;

    // R4: with division selected, an enable is never followed by another.
    assert_prescale_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel && cnt_en) |=> (!cnt_en || !div_sel));
endmodule

// File: rtl/baud_period.sv
// Module: baud_period
// Counts enabled clocks to form one sample period of integer length
// plus a one-clock stretch. The stretch comes from the carry of a
// fraction accumulator. A new divisor is loaded only at a period end,
// or from idle.
// Assumes: cnt_en comes from baud_prescale. A divisor of 0 means stop.
module baud_period #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              fire,
    output logic              running,
    output logic              sample_q
);
    localparam int LEN_W = DIV_W + 1;

    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;
    logic [LEN_W-1:0]  new_len;
    logic              load;

    // Next accumulator value and the length of the next period.
    always_comb begin
        sum     = {1'b0, acc} + {1'b0, frac_in};
        new_len = {1'b0, div_in} + LEN_W'(sum[FRAC_W]);
    end

    // Period end: last enabled clock of a running period.
    always_comb fire = cnt_en && running && (cnt == len - LEN_W'(1));
    always_comb load = cnt_en && (!running || fire);

    // Period state: load at the boundary, else count enabled clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len     <= '0;
            cnt     <= '0;
            acc     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt <= '0;
            if (div_in != '0) begin
                len     <= new_len;
                acc     <= sum[FRAC_W-1:0];
                running <= 1'b1;
            end else begin
                len     <= '0;
                acc     <= '0;
                running <= 1'b0;
            end
        end else if (cnt_en && running) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Registered sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_q <= 1'b0;
        else        sample_q <= fire;
    end

    // R2: the count never reaches the loaded length while running.
    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < len));
    // R7: the period length changes only at a load.
    assert_len_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load) |=> $stable(len));
    // R6: a stopped counter produces no strobe on the next clock.
    assert_no_tick_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !sample_q);
endmodule

// File: rtl/baud_bitcount.sv
// Module: baud_bitcount
// Counts sample strobes and flags the last sample of each bit. The
// oversampling mode is taken at a bit boundary, or while stopped.
// Assumes: fire and running come from baud_period. OS_LO < OS_HI.
module baud_bitcount #(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic running,
    input  logic os_sel,
    output logic bit_q
);
    import baud_pkg::*;
    localparam int CW = $clog2(OS_HI);

    logic [CW-1:0] scnt;
    os_mode_e      act_mode;
    logic [CW-1:0] last;

    // Index of the final sample in the active mode.
    always_comb last = (act_mode == OS_8X) ? CW'(OS_LO - 1) : CW'(OS_HI - 1);

    // Sample index and mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scnt     <= '0;
            act_mode <= OS_16X;
        end else if (!running) begin
            scnt     <= '0;
            act_mode <= os_mode_e'(os_sel);
        end else if (fire) begin
            if (scnt == last) begin
                scnt     <= '0;
                act_mode <= os_mode_e'(os_sel);
            end else begin
                scnt <= scnt + 1'b1;
            end
        end
    end

    // Registered bit strobe, aligned with the sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= running && fire && (scnt == last);
    end

    // R5 / R8: the sample index stays inside the active mode's range.
    assert_scnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scnt <= last);
endmodule

// File: rtl/frac_baud_gen.sv
// Module: frac_baud_gen (top)
// Fractional baud rate generator for one serial channel: an optional
// divide-by-4, a fractional period counter, and a sample-to-bit counter.
// Assumes: the divisor inputs are held in registers outside the block.
// A changed value is taken at the next period end.
module frac_baud_gen #(
    parameter int BYTE_W    = 8,
    parameter int FRAC_W    = 4,
    parameter int PRE_RATIO = 4,
    parameter int OS_HI     = 16,
    parameter int OS_LO     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              pre_div4,
    input  logic              os_8x,
    output logic              sample_tick,
    output logic              bit_tick
);
    localparam int DIV_W = 2 * BYTE_W;

    logic             cnt_en;
    logic             fire;
    logic             running;
    logic [DIV_W-1:0] div_full;

    // Join the two divisor bytes.
    always_comb div_full = {div_hi, div_lo};

    baud_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_sel(pre_div4), .cnt_en(cnt_en)
    );

    baud_period #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_period (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .div_in(div_full),
        .frac_in(div_frac), .fire(fire), .running(running),
        .sample_q(sample_tick)
    );

    baud_bitcount #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_bits (
        .clk(clk), .rst_n(rst_n), .fire(fire), .running(running),
        .os_sel(os_8x), .bit_q(bit_tick)
    );

    // R5: a bit strobe is always also a sample strobe.
    assert_bit_with_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
    // R1: both strobes are low in the cycle after a reset clock.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/frac_baud_gen_tb.sv
// Bench for frac_baud_gen. An integer reference model steps on each
// rising edge. The outputs are compared with it at every falling edge.
// Windowed pulse counts check the rates.
module frac_baud_gen_tb_top;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = '0;
    logic [7:0] div_hi = '0;
    logic [3:0] div_frac = '0;
    logic       pre_div4 = 1'b0;
    logic       os_8x = 1'b0;
    logic       sample_tick;
    logic       bit_tick;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    frac_baud_gen dut_i (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .div_frac(div_frac), .pre_div4(pre_div4), .os_8x(os_8x),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    // Reference model state, integers only.
    int m_phase, m_len, m_cnt, m_acc, m_sidx;
    bit m_run, m_os8, exp_s, exp_b;

    // Model one clock edge of the requirements R1..R8.
    always @(posedge clk) begin
        int  d, s, last;
        bit  en, f, b, old_run;
        if (!rst_n) begin
            m_phase = 0; m_len = 0; m_cnt = 0; m_acc = 0; m_sidx = 0;
            m_run = 0; m_os8 = 0; exp_s = 0; exp_b = 0;
        end else begin
            d  = {div_hi, div_lo};
            en = pre_div4 ? (m_phase == 3) : 1'b1;
            m_phase = (m_phase + 1) % 4;
            old_run = m_run;
            f = 0; b = 0;
            if (en) begin
                if (m_run && (m_cnt + 1 == m_len)) f = 1;
                if (!m_run || f) begin
                    m_cnt = 0;
                    if (d != 0) begin
                        s = m_acc + div_frac;
                        m_len = d + (s >= 16 ? 1 : 0);
                        m_acc = s % 16;
                        m_run = 1;
                    end else begin
                        m_len = 0; m_acc = 0; m_run = 0;
                    end
                end else if (m_run) begin
                    m_cnt++;
                end
            end
            last = m_os8 ? 7 : 15;
            if (!old_run) begin
                m_sidx = 0; m_os8 = os_8x;
            end else if (f) begin
                if (m_sidx == last) begin
                    b = 1; m_sidx = 0; m_os8 = os_8x;
                end else m_sidx++;
            end
            exp_s = f; exp_b = b;
        end
    end

    // Compare the outputs with the model every cycle.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (sample_tick !== exp_s || bit_tick !== exp_b) begin
                failures++;
                $display("FAIL %s cycle compare: actual s=%0b b=%0b expected s=%0b b=%0b",
                         cur_req, sample_tick, bit_tick, exp_s, exp_b);
            end
        end
    end

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic count_win(int n, output int s, output int b);
        s = 0; b = 0;
        repeat (n) begin
            @(negedge clk);
            s += sample_tick;
            b += bit_tick;
        end
    endtask

    task automatic gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!sample_tick);
    endtask

    task automatic setup(int d, int f, bit p, bit o);
        @(negedge clk);
        div_hi = 8'(d >> 8); div_lo = 8'(d); div_frac = 4'(f);
        pre_div4 = p; os_8x = o;
    endtask

    initial begin
        int s, b, g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and quiet outputs with zero divisors.
        check_eq("R1", "sample after reset", int'(sample_tick), 0);
        check_eq("R1", "bit after reset", int'(bit_tick), 0);
        count_win(50, s, b);
        check_eq("R6", "strobes with zero divisor", s + b, 0);

        cur_req = "R2";
        setup(5, 0, 0, 0);
        repeat (40) @(negedge clk);
        count_win(160, s, b);
        check_eq("R2", "pulses D=5 in 160", s, 32);
        count_win(400, s, b);
        check_eq("R5", "16x bits in 400 at D=5", b, 5);

        cur_req = "R3";
        setup(5, 4, 0, 0);
        repeat (100) @(negedge clk);
        count_win(336, s, b);
        check_eq("R3", "pulses D=5 F=4 in 336", s, 64);

        setup(3, 15, 0, 0);
        repeat (100) @(negedge clk);
        count_win(630, s, b);
        check_eq("R3", "pulses D=3 F=15 in 630", s, 160);

        cur_req = "R4";
        setup(2, 0, 1, 0);
        repeat (80) @(negedge clk);
        count_win(400, s, b);
        check_eq("R4", "pulses D=2 div4 in 400", s, 50);
        gap(g); gap(g);
        check_eq("R4", "gap D=2 div4", g, 8);

        cur_req = "R5";
        setup(2, 0, 0, 0);
        repeat (100) @(negedge clk);
        count_win(320, s, b);
        check_eq("R5", "16x bits D=2 in 320", b, 10);
        cur_req = "R8";
        setup(2, 0, 0, 1);
        repeat (100) @(negedge clk);
        count_win(320, s, b);
        check_eq("R8", "8x bits D=2 in 320", b, 20);
        check_eq("R5", "8x samples D=2 in 320", s, 160);

        cur_req = "R7";
        setup(20, 0, 0, 0);
        repeat (60) @(negedge clk);
        gap(g);
        repeat (3) @(negedge clk);
        div_lo = 8'd3;
        gap(g);
        check_eq("R7", "gap after mid-period write", g + 3, 20);
        gap(g);
        check_eq("R7", "first gap with new divisor", g, 3);

        cur_req = "R6";
        setup(0, 7, 0, 0);
        repeat (30) @(negedge clk);
        count_win(200, s, b);
        check_eq("R6", "strobes after stop", s + b, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule